// File: doc/BRIEF.md
# Packed Decimal Field Comparator

This block is a small sequential engine that compares two signed packed-decimal numbers held in byte-addressed memory and reports their algebraic order as a 2-bit condition code. Each operand is a run of bytes with two decimal digits per byte. The exception is the final byte, which carries one digit in its upper nibble and the sign in its lower nibble.

A caller presents the two start addresses and one length byte, then pulses `start`. The engine reads every byte of both operands through a single byte-wide read port that uses a request/valid handshake. It right-aligns the operands so that a shorter one is compared as if padded with leading zero digits, and it walks the aligned bytes from the most significant end. When the walk finishes, it pulses `done` together with either a condition code or a data-exception flag. It never writes memory.

Top module: `pdec_cmp`

## Requirements
- R1: `len_code[7:4]` holds the byte length of operand 1 minus one, and `len_code[3:0]` holds the byte length of operand 2 minus one. For example, 0x32 selects a 4-byte operand 1 and a 3-byte operand 2.
- R2: On a valid comparison, `cc` at the `done` pulse is 0 when the operands are equal, 1 when operand 1 is lower and 2 when operand 1 is higher. The value 3 never appears.
- R3: When the lengths differ, the shorter operand is compared as if it had leading zero digits, so only numeric value decides the result.
- R4: The comparison is algebraic. Any positive value ranks above any negative value, two negative values order by inverted magnitude, and +0 equals -0.
- R5: The sign is the low nibble of the last byte of an operand. Nibbles 0xA, 0xC, 0xE and 0xF mean positive, and 0xB and 0xD mean negative.
- R6: If any digit nibble of either operand exceeds 9, or either sign nibble is below 0xA, `dexc` is 1 at the `done` pulse and `cc` keeps the value it had before.
- R7: `done` is high for exactly one cycle per accepted start. `cc` and `dexc` hold their values until the next `done`.
- R8: A `start` pulse that arrives while a comparison is running is ignored. The addresses and length given with it have no effect.
- R9: `mem_req` and `mem_addr` stay stable until `mem_rvalid` is seen. Each operand byte is read exactly once, so a run makes L1+L2+2 reads, all within the two operand ranges.
- R10: After a synchronous reset, `done`, `dexc`, `cc` and `mem_req` are all 0.
- R11: Operands up to the maximum of 16 bytes (31 digits and a sign) compare correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a comparison (sampled only when idle) |
| op1_addr | input | AW | Address of the first (most significant) byte of operand 1 |
| op2_addr | input | AW | Address of the first (most significant) byte of operand 2 |
| len_code | input | 2*LW | Length codes: operand 1 in the upper nibble, operand 2 in the lower |
| mem_req | output | 1 | Read request, held until accepted |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | Read data valid; completes the pending request |
| mem_rdata | input | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code: 0 equal, 1 operand 1 lower, 2 operand 1 higher |
| dexc | output | 1 | Data exception detected in the last comparison |

## Verification
The handshake assertion takes for granted that the memory raises `mem_rvalid` only while a request is pending and for a single cycle per request. The bench's memory model respects this by answering only when a request is open and no answer is already outstanding, with a latency that varies from 0 to 2 extra cycles. The condition-code assertions assume that `start` is not asserted in the same cycle a run completes. The bench pulses `start` only when the block is idle, except in the deliberate mid-run case, which it places well before completion.

// File: rtl/pdec_pkg.sv
// Shared types for the packed-decimal comparator.
// Assumes nothing beyond the encodings declared here.
package pdec_pkg;
    // Controller states of the fetch/compare walk
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_FA   = 3'd1,
        S_FB   = 3'd2,
        S_STEP = 3'd3,
        S_FIN  = 3'd4
    } pdec_state_t;

    // Relation codes double as the externally visible condition code
    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2
    } pdec_rel_t;
endpackage

// File: rtl/pdec_nib_chk.sv
// Classifies one byte of a packed-decimal operand.
// Non-final bytes carry two digits; the final byte carries one digit and a sign.
// Assumes is_last is asserted only for the least significant byte.
module pdec_nib_chk (
    input  logic [7:0] byte_in,
    input  logic       is_last,
    output logic       ok,
    output logic       neg,
    output logic       nz
);
    logic [3:0] hi_n;
    logic [3:0] lo_n;

    // Split the byte and judge each nibble by its role
    always_comb begin
        hi_n = byte_in[7:4];
        lo_n = byte_in[3:0];
        ok   = (hi_n <= 4'd9) && (is_last ? (lo_n >= 4'hA) : (lo_n <= 4'd9));
        neg  = is_last && ((lo_n == 4'hB) || (lo_n == 4'hD));
        nz   = (hi_n != 4'd0) || (!is_last && (lo_n != 4'd0));
    end
endmodule

// File: rtl/pdec_byte_eval.sv
// Evaluates one aligned byte position of both operands.
// Produces validity, sign, nonzero flags and the magnitude relation of the digits.
// Assumes padded positions are presented as 0x00.
module pdec_byte_eval
    import pdec_pkg::*;
(
    input  logic [1:0][7:0] bytes_in,
    input  logic            is_last,
    output logic            ok,
    output logic [1:0]      neg,
    output logic [1:0]      nz,
    output pdec_rel_t       rel
);
    logic [1:0] ok_v;
    logic [1:0][7:0] key;

    // One classifier per operand
    for (genvar g = 0; g < 2; g++) begin : g_op
        pdec_nib_chk u_chk (
            .byte_in (bytes_in[g]),
            .is_last (is_last),
            .ok      (ok_v[g]),
            .neg     (neg[g]),
            .nz      (nz[g])
        );
        // Sign nibble is masked out of the magnitude key on the final byte
        assign key[g] = is_last ? {bytes_in[g][7:4], 4'h0} : bytes_in[g];
    end

    // Combine validity and order the two digit keys
    always_comb begin
        ok = &ok_v;
        if (key[0] < key[1])      rel = REL_LT;
        else if (key[0] > key[1]) rel = REL_GT;
        else                      rel = REL_EQ;
    end
endmodule

// File: rtl/pdec_cmp.sv
// Packed-decimal field comparator.
// Walks both right-aligned operands from the most significant byte. For each
// position it reads operand 1 and then operand 2 (a padding position is not
// read). It latches the first magnitude difference, then applies the signs.
// Assumes mem_rvalid arrives only while mem_req is high, once per request.
module pdec_cmp
    import pdec_pkg::*;
#(
    parameter int AW   = 16,
    parameter int MAXB = 16,
    localparam int LW  = $clog2(MAXB),
    localparam int CW  = LW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   op1_addr,
    input  logic [AW-1:0]   op2_addr,
    input  logic [2*LW-1:0] len_code,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [7:0]      mem_rdata,
    output logic            done,
    output logic [1:0]      cc,
    output logic            dexc
);
    pdec_state_t     state;
    logic [CW-1:0]   k, nb, len1, len2;
    logic [AW-1:0]   a1, a2;
    logic [1:0][7:0] bytes_r;
    pdec_rel_t       rel_r, byte_rel, fin_rel;
    logic            bad_r, ok_b;
    logic [1:0]      nz_r, neg_r, nz_b, neg_b;
    logic [CW-1:0]   pad1, pad2, l1n, l2n;
    logic            ex1, ex2, is_last;

    // Alignment: which operand bytes exist at walk position k
    always_comb begin
        pad1    = nb - len1;
        pad2    = nb - len2;
        ex1     = (k >= pad1);
        ex2     = (k >= pad2);
        is_last = (k == nb - CW'(1));
        l1n     = CW'(len_code[2*LW-1:LW]) + CW'(1);
        l2n     = CW'(len_code[LW-1:0]) + CW'(1);
    end

    // Read port: request the existing byte of the operand being fetched
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = a1 + AW'(k - pad1);
        if (state == S_FA && ex1) begin
            mem_req = 1'b1;
        end else if (state == S_FB && ex2) begin
            mem_req  = 1'b1;
            mem_addr = a2 + AW'(k - pad2);
        end
    end

    pdec_byte_eval u_eval (
        .bytes_in (bytes_r),
        .is_last  (is_last),
        .ok       (ok_b),
        .neg      (neg_b),
        .nz       (nz_b),
        .rel      (byte_rel)
    );

    // Apply signs to the magnitude relation; a zero is never negative
    always_comb begin
        logic en1, en2;
        en1 = neg_r[0] & nz_r[0];
        en2 = neg_r[1] & nz_r[1];
        if (en1 && !en2)      fin_rel = REL_LT;
        else if (!en1 && en2) fin_rel = REL_GT;
        else if (en1)         fin_rel = (rel_r == REL_LT) ? REL_GT :
                                        (rel_r == REL_GT) ? REL_LT : REL_EQ;
        else                  fin_rel = rel_r;
    end

    // Controller: fetch, evaluate and report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            k       <= '0;
            nb      <= '0;
            len1    <= '0;
            len2    <= '0;
            a1      <= '0;
            a2      <= '0;
            bytes_r <= '0;
            rel_r   <= REL_EQ;
            bad_r   <= 1'b0;
            nz_r    <= '0;
            neg_r   <= '0;
            done    <= 1'b0;
            cc      <= 2'd0;
            dexc    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    a1    <= op1_addr;
                    a2    <= op2_addr;
                    len1  <= l1n;
                    len2  <= l2n;
                    nb    <= (l1n > l2n) ? l1n : l2n;
                    k     <= '0;
                    rel_r <= REL_EQ;
                    bad_r <= 1'b0;
                    nz_r  <= '0;
                    neg_r <= '0;
                    state <= S_FA;
                end
                S_FA: begin
                    if (!ex1) begin
                        bytes_r[0] <= 8'h00;
                        state      <= S_FB;
                    end else if (mem_rvalid) begin
                        bytes_r[0] <= mem_rdata;
                        state      <= S_FB;
                    end
                end
                S_FB: begin
                    if (!ex2) begin
                        bytes_r[1] <= 8'h00;
                        state      <= S_STEP;
                    end else if (mem_rvalid) begin
                        bytes_r[1] <= mem_rdata;
                        state      <= S_STEP;
                    end
                end
                S_STEP: begin
                    bad_r <= bad_r | !ok_b;
                    nz_r  <= nz_r | nz_b;
                    if (rel_r == REL_EQ) rel_r <= byte_rel;
                    if (is_last) begin
                        neg_r <= neg_b;
                        state <= S_FIN;
                    end else begin
                        k     <= k + CW'(1);
                        state <= S_FA;
                    end
                end
                S_FIN: begin
                    done  <= 1'b1;
                    dexc  <= bad_r;
                    if (!bad_r) cc <= fin_rel;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Completion is a single-cycle pulse (R7)
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A pending read holds its address until accepted (R9)
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // No read is outstanding when a result is reported (R9)
    p_no_req_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // Valid results never use code 3 (R2)
    p_cc_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !dexc |-> cc != 2'd3);

    // A data exception leaves the condition code untouched (R6)
    p_cc_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done && dexc |-> cc == $past(cc));
endmodule

// File: tb/tb_pdec_cmp.sv
module tb_pdec_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] op1_addr = '0, op2_addr = '0;
    logic [7:0]  len_code = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        done, dexc;
    logic [1:0]  cc;

    int n_chk = 0, n_bad = 0;
    int dly = 0, lat_cnt = 0;
    int rd_cnt = 0, rd_out = 0, done_cnt = 0;
    int lo1 = 0, hi1 = 0, lo2 = 0, hi2 = 0;
    logic [7:0] mem [256];

    always #2.5 clk = ~clk;

    pdec_cmp dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op1_addr(op1_addr), .op2_addr(op2_addr), .len_code(len_code),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .cc(cc), .dexc(dexc)
    );

    // Memory model with configurable latency; one answer per request
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req && !mem_rvalid) begin
            if (lat_cnt >= dly) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[7:0]];
                lat_cnt    <= 0;
            end else lat_cnt <= lat_cnt + 1;
        end
    end

    // Read and completion tracking
    always @(posedge clk) begin
        if (mem_req && mem_rvalid) begin
            rd_cnt++;
            if (!((mem_addr >= 16'(lo1) && mem_addr <= 16'(hi1)) ||
                  (mem_addr >= 16'(lo2) && mem_addr <= 16'(hi2)))) rd_out++;
        end
        if (done) done_cnt++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int base, input int l, input logic [127:0] v);
        for (int j = 0; j <= l; j++) mem[base + j] = v[8*(l-j) +: 8];
    endtask

    task automatic run(input logic [7:0] lc, input int b1, input int b2, output bit ok);
        op1_addr = 16'(b1); op2_addr = 16'(b2); len_code = lc;
        lo1 = b1; hi1 = b1 + int'(lc[7:4]); lo2 = b2; hi2 = b2 + int'(lc[3:0]);
        rd_cnt = 0; rd_out = 0; done_cnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        ok = 1'b0;
        for (int t = 0; t < 2000; t++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic [7:0]   len;
        logic [127:0] a;
        logic [127:0] b;
        logic [1:0]   cc;
        logic         exc;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 128'h1C, 128'h1C, 2'd0, 1'b0, 4'd2},              // R2 equal
        '{8'h00, 128'h2C, 128'h3C, 2'd1, 1'b0, 4'd2},              // R2 lower
        '{8'h00, 128'h5C, 128'h3F, 2'd2, 1'b0, 4'd2},              // R2 higher
        '{8'h32, 128'h0012345C, 128'h12345C, 2'd0, 1'b0, 4'd1},    // R1 0x32 split
        '{8'h32, 128'h1000000C, 128'h99999C, 2'd2, 1'b0, 4'd3},    // R3 padding
        '{8'h23, 128'h99999D, 128'h0000001C, 2'd1, 1'b0, 4'd3},    // R3 shorter op1
        '{8'h11, 128'h000C, 128'h000D, 2'd0, 1'b0, 4'd4},          // R4 +0 = -0
        '{8'h11, 128'h001D, 128'h000C, 2'd1, 1'b0, 4'd4},          // R4 -1 < 0
        '{8'h11, 128'h005D, 128'h003B, 2'd1, 1'b0, 4'd4},          // R4 -5 < -3
        '{8'h11, 128'h003D, 128'h005D, 2'd2, 1'b0, 4'd4},          // R4 -3 > -5
        '{8'h00, 128'h1A, 128'h1E, 2'd0, 1'b0, 4'd5},              // R5 A,E positive
        '{8'h00, 128'h2F, 128'h9B, 2'd2, 1'b0, 4'd5},              // R5 F pos, B neg
        '{8'h11, 128'h123C, 128'h124C, 2'd1, 1'b0, 4'd2},          // R2 last digit decides
        '{8'hFF, 128'h9999_9999_9999_9999_9999_9999_9999_999C,
                 128'h8999_9999_9999_9999_9999_9999_9999_999C, 2'd2, 1'b0, 4'd11}, // R11
        '{8'h00, 128'hAC, 128'h1C, 2'd2, 1'b0 | 1'b1, 4'd6},       // R6 bad digit, cc kept 2
        '{8'hF0, 128'h0D, 128'h0C, 2'd0, 1'b0, 4'd11},             // R11 16-byte -0 = +0
        '{8'h00, 128'h15, 128'h1C, 2'd0, 1'b1, 4'd6},              // R6 bad sign
        '{8'h01, 128'h1C, 128'h0F1C, 2'd0, 1'b1, 4'd6}             // R6 bad digit in op2
    };

    function automatic string rtag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            default: return "R11";
        endcase
    endfunction

    initial begin
        bit ok;
        logic [1:0] cc_hold;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R10 reset state
        check("R10 done", int'(done), 0);
        check("R10 cc", int'(cc), 0);
        check("R10 dexc", int'(dexc), 0);
        check("R10 mem_req", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[i]) begin
            dly = i % 3;
            load(16, int'(VECS[i].len[7:4]), VECS[i].a);
            load(64, int'(VECS[i].len[3:0]), VECS[i].b);
            run(VECS[i].len, 16, 64, ok);
            check({rtag(VECS[i].req), " finished"}, int'(ok), 1);
            check({rtag(VECS[i].req), " cc"}, int'(cc), int'(VECS[i].cc));
            check({rtag(VECS[i].req), " dexc"}, int'(dexc), int'(VECS[i].exc));
            check("R9 read count", rd_cnt, int'(VECS[i].len[7:4]) + int'(VECS[i].len[3:0]) + 2);
            check("R9 read range", rd_out, 0);
            @(negedge clk);
        end

        // R7: single pulse, results held afterwards
        cc_hold = cc;
        repeat (5) @(negedge clk);
        check("R7 done width", done_cnt, 1);
        check("R7 done low", int'(done), 0);
        check("R7 cc held", int'(cc), int'(cc_hold));

        // R8: second start mid-run with other operands is ignored
        dly = 1;
        load(16, 1, 128'h123C); load(64, 1, 128'h124C);
        load(128, 0, 128'h9C);  load(160, 0, 128'h1C);
        op1_addr = 16'd16; op2_addr = 16'd64; len_code = 8'h11;
        lo1 = 16; hi1 = 17; lo2 = 64; hi2 = 65;
        rd_cnt = 0; rd_out = 0; done_cnt = 0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        op1_addr = 16'd128; op2_addr = 16'd160; len_code = 8'h00;
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int t = 0; t < 2000 && !done; t++) @(negedge clk);
        check("R8 cc from first start", int'(cc), 1);
        check("R8 reads", rd_cnt, 4);
        check("R8 read range", rd_out, 0);
        repeat (20) @(negedge clk);
        check("R8 single done", done_cnt, 1);

        // R10: reset in the middle of a run
        load(16, 0, 128'h5C); load(64, 0, 128'h3C);
        op1_addr = 16'd16; op2_addr = 16'd64; len_code = 8'h00;
        dly = 2;
        start = 1'b1; @(negedge clk); start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; @(negedge clk); @(negedge clk);
        check("R10 mid reset mem_req", int'(mem_req), 0);
        check("R10 mid reset cc", int'(cc), 0);
        check("R10 mid reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule